// File: doc/BRIEF.md
# Address Area Decoder with Wait-State Sequencer

This block sits between a processor's bus cycle engine and the external memory bus. When a bus cycle starts, it compares the 24-bit address with four programmable address areas. It drives the active-low select of the winning area for the whole cycle. It also reports whether that area uses an 8-bit or a 16-bit data bus, and it counts out the wait states that the area's wait code asks for. A one-clock ready pulse closes the cycle. An address that no enabled area claims still runs a cycle. In that case no select goes low, and the width and wait code come from a separate default register.

Each area has a write-only control byte that holds an enable, a waveform field, a width bit and a 3-bit wait code. It also has a base register and a mask register, each as wide as the address. Area 2 comes out of reset enabled and covering every address. A scope bit then narrows it to its own base and mask. One wait code inserts one wait state and then holds the cycle open while the external WAIT line stays low. The same block grants the bus to an external requester, but never while WAIT is low and never while a cycle is running.

Top module: `area_wait_ctrl`

## Requirements
- R1: After reset, every select output is high, `bus8`, `cyc_rdy` and `bus_ack` are low. Area 2 is enabled with its scope bit clear, so the first cycle at any address selects area 2 with wait code 000.
- R2: An area claims a cycle when all of the following hold: it is enabled, its waveform field is 00, and `((addr ^ base) & mask) == 0` over all 24 bits. Its select output is low from the clock after the accepted start until the clock on which ready rises. An area whose waveform field is nonzero never claims a cycle.
- R3: When several areas claim the same address, only the lowest-numbered one drives its select low.
- R4: If no area claims the address, all selects stay high. The cycle takes its width and wait code from the default register.
- R5: A start sampled on clock edge k with a fixed wait code of W waits makes `cyc_rdy` high for exactly one clock after edge k+W+1. The code values are: 000 gives 2, 001 gives 1, 101 gives 3, 110 gives 4 and 111 gives 8. WAIT has no effect on these codes.
- R6: Wait code 011 completes with zero waits (ready after edge k+1), even while WAIT is low.
- R7: Wait code 010 counts one wait state and then samples WAIT on every edge. Ready follows the first edge, from k+2 onward, on which WAIT is high.
- R8: `bus8` equals the width bit of the area that owns the cycle (1 means 8-bit) for the duration of the cycle, and is 0 when no cycle runs.
- R9: A start seen while a cycle is running, or while the bus is granted, is ignored. No new cycle follows it.
- R10: `bus_ack` rises one clock after an edge that sees all of these: `bus_req` high, WAIT high, no cycle running and no start. It stays high while `bus_req` and WAIT are both high. It falls one clock after either one goes low. When a start and a request arrive together, the cycle runs first.
- R11: Area 2's scope bit (control byte bit 6) set to 1 limits area 2 to its base/mask match. When the bit is clear, area 2 claims every address. Bit 6 has no effect on the other areas.
- R12: Registers are written through `cfg_idx` = {region[1:0], area[1:0], byte[1:0]}, as follows:
  - Region 0 is an area control byte, laid out as enable[7], scope[6], waveform[5:4], width[3], wait code[2:0].
  - Region 1 is the default register, laid out as width[3], wait code[2:0].
  - Region 2 is a base byte and region 3 a mask byte. Byte 0 covers address bits 7:0 and byte 2 covers bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 6 | Register index {region, area, byte} |
| cfg_data | input | 8 | Register write data |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_addr | input | 24 | Address of the starting cycle |
| wait_n | input | 1 | External WAIT line, low requests wait |
| bus_req | input | 1 | External bus request |
| cs_n | output | 4 | Active-low area selects |
| bus8 | output | 1 | Current cycle uses an 8-bit data bus |
| cyc_rdy | output | 1 | One-clock end-of-cycle pulse |
| bus_ack | output | 1 | Bus granted to the requester |

## Verification
Two functions can meet in the same clock: the start of a bus cycle and the grant of the bus. The bench raises `bus_req` in the same clock as `cyc_start`, then judges that the cycle owns the bus and that the grant lands exactly one clock after ready. It also issues a start while the bus is granted and expects no select to move. Finally it drops WAIT under a standing grant and expects the grant to withdraw on the next clock. A behavioural model predicts every output on every clock, so that each of these collisions is checked cycle by cycle.

// File: rtl/awc_pkg.sv
package awc_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;

    typedef logic [CODE_W-1:0] wcode_t;

    // Area control byte, MSB first.
    typedef struct packed {
        logic       en;
        logic       narrow_scope;
        logic [1:0] shape;
        logic       w8;
        wcode_t     code;
    } area_ctl_t;

    // Default-area register.
    typedef struct packed {
        logic   w8;
        wcode_t code;
    } dflt_ctl_t;

    // Number of wait states counted before ready (stretch code counts one first).
    function automatic logic [CNT_W-1:0] wait_states(input wcode_t c);
        logic [CNT_W-1:0] n;
        case (c)
            3'b000:  n = 4'd2;
            3'b001:  n = 4'd1;
            3'b010:  n = 4'd1;
            3'b011:  n = 4'd0;
            3'b101:  n = 4'd3;
            3'b110:  n = 4'd4;
            3'b111:  n = 4'd8;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

    function automatic logic is_stretch(input wcode_t c);
        return c == 3'b010;
    endfunction

endpackage

// File: rtl/awc_decode.sv
module awc_decode
    import awc_pkg::*;
#(
    parameter int N_AREA    = 4,
    parameter int ADDR_W    = 24,
    parameter int FULL_AREA = 2
)(
    input  logic [ADDR_W-1:0]              addr,
    input  area_ctl_t [N_AREA-1:0]         ctl,
    input  logic [N_AREA-1:0][ADDR_W-1:0]  base,
    input  logic [N_AREA-1:0][ADDR_W-1:0]  mask,
    output logic [N_AREA-1:0]              hit_oh
);

    logic [N_AREA-1:0] raw;

    generate
        for (genvar g = 0; g < N_AREA; g++) begin : g_area
            localparam bit IS_FULL = (g == FULL_AREA);
            logic in_win;
            assign in_win = ((addr ^ base[g]) & mask[g]) == '0;
            assign raw[g] = ctl[g].en && (ctl[g].shape == 2'b00) &&
                            (in_win || (IS_FULL && !ctl[g].narrow_scope));
        end
    endgenerate

    // Lowest-numbered claimant wins.
    always_comb begin
        logic taken;
        hit_oh = '0;
        taken  = 1'b0;
        for (int i = 0; i < N_AREA; i++) begin
            if (raw[i] && !taken) begin
                hit_oh[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/awc_seq.sv
module awc_seq
    import awc_pkg::*;
#(
    parameter int N_AREA = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hold,
    input  logic              wait_n,
    input  logic [N_AREA-1:0] hit_oh,
    input  logic              w8_sel,
    input  wcode_t            code_sel,
    output logic [N_AREA-1:0] cs_n,
    output logic              w8,
    output logic              rdy,
    output logic              busy
);

    typedef struct packed {
        logic              busy;
        logic              stretch;
        logic [CNT_W-1:0]  left;
        logic [N_AREA-1:0] act;
        logic              w8;
        logic              rdy;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        if (s_q.busy) begin
            if (s_q.left != '0) begin
                s_d.left = s_q.left - 1'b1;
            end else if (!s_q.stretch || wait_n) begin
                s_d.busy    = 1'b0;
                s_d.stretch = 1'b0;
                s_d.act     = '0;
                s_d.w8      = 1'b0;
                s_d.rdy     = 1'b1;
            end
        end else if (start && !hold) begin
            s_d.busy    = 1'b1;
            s_d.stretch = is_stretch(code_sel);
            s_d.left    = wait_states(code_sel);
            s_d.act     = hit_oh;
            s_d.w8      = w8_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cs_n = ~s_q.act;
    assign w8   = s_q.w8;
    assign rdy  = s_q.rdy;
    assign busy = s_q.busy;

endmodule

// File: rtl/awc_grant.sv
module awc_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic wait_n,
    input  logic busy,
    input  logic start,
    output logic ack
);

    typedef struct packed {
        logic ack;
    } grant_t;

    grant_t g_d, g_q;

    always_comb begin
        g_d.ack = bus_req && wait_n && (g_q.ack || (!busy && !start));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign ack = g_q.ack;

endmodule

// File: rtl/area_wait_ctrl.sv
module area_wait_ctrl
    import awc_pkg::*;
#(
    parameter int N_AREA    = 4,
    parameter int ADDR_W    = 24,
    parameter int FULL_AREA = 2,
    localparam int SEL_W  = (N_AREA > 1) ? $clog2(N_AREA) : 1,
    localparam int N_BYTE = ADDR_W / 8,
    localparam int BYTE_W = (N_BYTE > 1) ? $clog2(N_BYTE) : 1,
    localparam int IDX_W  = 2 + SEL_W + BYTE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_data,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              wait_n,
    input  logic              bus_req,
    output logic [N_AREA-1:0] cs_n,
    output logic              bus8,
    output logic              cyc_rdy,
    output logic              bus_ack
);

    typedef struct packed {
        area_ctl_t [N_AREA-1:0]         ctl;
        logic [N_AREA-1:0][ADDR_W-1:0]  base;
        logic [N_AREA-1:0][ADDR_W-1:0]  mask;
        dflt_ctl_t                      dflt;
    } cfg_t;

    cfg_t r_d, r_q;

    logic [1:0]        region;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] byt;

    assign region = cfg_idx[IDX_W-1 -: 2];
    assign sel    = cfg_idx[BYTE_W +: SEL_W];
    assign byt    = cfg_idx[BYTE_W-1:0];

    // Register write path.
    always_comb begin
        r_d = r_q;
        if (cfg_we && (int'(sel) < N_AREA || region == 2'b01)) begin
            case (region)
                2'b00: begin
                    r_d.ctl[sel] = area_ctl_t'(cfg_data);
                    if (sel != SEL_W'(FULL_AREA)) r_d.ctl[sel].narrow_scope = 1'b0;
                end
                2'b01: r_d.dflt = dflt_ctl_t'(cfg_data[$bits(dflt_ctl_t)-1:0]);
                2'b10: if (int'(byt) < N_BYTE) r_d.base[sel][{byt, 3'b000} +: 8] = cfg_data;
                default: if (int'(byt) < N_BYTE) r_d.mask[sel][{byt, 3'b000} +: 8] = cfg_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q                <= '0;
            r_q.ctl[FULL_AREA].en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    logic [N_AREA-1:0] hit_oh;
    logic              pick_w8;
    wcode_t            pick_code;
    logic              seq_busy;

    awc_decode #(
        .N_AREA    (N_AREA),
        .ADDR_W    (ADDR_W),
        .FULL_AREA (FULL_AREA)
    ) u_decode (
        .addr   (cyc_addr),
        .ctl    (r_q.ctl),
        .base   (r_q.base),
        .mask   (r_q.mask),
        .hit_oh (hit_oh)
    );

    // Width and wait code of the winning area, default area otherwise.
    always_comb begin
        pick_w8   = r_q.dflt.w8;
        pick_code = r_q.dflt.code;
        for (int i = 0; i < N_AREA; i++) begin
            if (hit_oh[i]) begin
                pick_w8   = r_q.ctl[i].w8;
                pick_code = r_q.ctl[i].code;
            end
        end
    end

    awc_seq #(
        .N_AREA (N_AREA)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .hold     (bus_ack),
        .wait_n   (wait_n),
        .hit_oh   (hit_oh),
        .w8_sel   (pick_w8),
        .code_sel (pick_code),
        .cs_n     (cs_n),
        .w8       (bus8),
        .rdy      (cyc_rdy),
        .busy     (seq_busy)
    );

    awc_grant u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_req (bus_req),
        .wait_n  (wait_n),
        .busy    (seq_busy),
        .start   (cyc_start),
        .ack     (bus_ack)
    );

endmodule

// File: rtl/awc_chk.sv
module awc_chk #(
    parameter int N_AREA = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              wait_n,
    input logic              bus_req,
    input logic [N_AREA-1:0] cs_n,
    input logic              bus8,
    input logic              cyc_rdy,
    input logic              bus_ack
);

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5
    single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_rdy |=> !cyc_rdy);

    // R2
    release_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_rdy |-> (&cs_n) && !bus8);

    // R9
    select_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !$stable(cs_n)) |-> $past(&cs_n));

    // R10
    grant_wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(wait_n && bus_req));

    // R10
    grant_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (&cs_n) && !bus8 && !cyc_rdy);

endmodule

bind area_wait_ctrl awc_chk #(.N_AREA(N_AREA)) u_awc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_n  (wait_n),
    .bus_req (bus_req),
    .cs_n    (cs_n),
    .bus8    (bus8),
    .cyc_rdy (cyc_rdy),
    .bus_ack (bus_ack)
);

// File: tb/area_wait_ctrl_bench.sv
module area_wait_ctrl_bench;

    localparam int N  = 4;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic        cyc_start = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic        wait_n = 1'b1;
    logic        bus_req = 1'b0;
    logic [3:0]  cs_n;
    logic        bus8, cyc_rdy, bus_ack;

    always #10 clk = ~clk;

    area_wait_ctrl u_area_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .wait_n(wait_n), .bus_req(bus_req), .cs_n(cs_n), .bus8(bus8),
        .cyc_rdy(cyc_rdy), .bus_ack(bus_ack)
    );

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_en[N], m_scope[N], m_shape[N], m_w8[N], m_code[N], m_base[N], m_mask[N];
    int d_w8, d_code;
    int m_busy, m_left, m_str, m_cs, m_bw, m_rdy, m_ack;
    int waits_tbl[8] = '{2, 1, 1, 0, 0, 3, 4, 8};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_en[i] = (i == 2); m_scope[i] = 0; m_shape[i] = 0;
                m_w8[i] = 0; m_code[i] = 0; m_base[i] = 0; m_mask[i] = 0;
            end
            d_w8 = 0; d_code = 0;
            m_busy = 0; m_left = 0; m_str = 0; m_cs = -1; m_bw = 0; m_rdy = 0; m_ack = 0;
        end else begin
            int nack, hit, a, b, rg, adr;
            nack  = (bus_req && wait_n && (m_ack || (!m_busy && !cyc_start))) ? 1 : 0;
            m_rdy = 0;
            if (m_busy) begin
                if (m_left > 0) m_left--;
                else if (!m_str || wait_n) begin
                    m_busy = 0; m_cs = -1; m_bw = 0; m_rdy = 1; m_str = 0;
                end
            end else if (cyc_start && !m_ack) begin
                adr = int'(cyc_addr);
                hit = -1;
                for (int i = 0; i < N; i++)
                    if (hit < 0 && m_en[i] && m_shape[i] == 0 &&
                        (((adr ^ m_base[i]) & m_mask[i]) == 0 || (i == 2 && !m_scope[i])))
                        hit = i;
                m_busy = 1; m_cs = hit;
                if (hit >= 0) begin
                    m_bw = m_w8[hit]; m_left = waits_tbl[m_code[hit]]; m_str = (m_code[hit] == 2);
                end else begin
                    m_bw = d_w8; m_left = waits_tbl[d_code]; m_str = (d_code == 2);
                end
            end
            if (cfg_we) begin
                rg = int'(cfg_idx) >> 4; a = (int'(cfg_idx) >> 2) & 3; b = int'(cfg_idx) & 3;
                case (rg)
                    0: begin
                        m_en[a] = cfg_data[7]; m_scope[a] = (a == 2) ? int'(cfg_data[6]) : 0;
                        m_shape[a] = cfg_data[5:4]; m_w8[a] = cfg_data[3]; m_code[a] = cfg_data[2:0];
                    end
                    1: begin d_w8 = cfg_data[3]; d_code = cfg_data[2:0]; end
                    2: if (b < 3) m_base[a] = (m_base[a] & ~(255 << (8*b))) | (int'(cfg_data) << (8*b));
                    default: if (b < 3) m_mask[a] = (m_mask[a] & ~(255 << (8*b))) | (int'(cfg_data) << (8*b));
                endcase
            end
            m_ack = nack;
        end
    end

    // Clock-by-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model cs_n", cs_n, (m_cs < 0) ? 15 : (15 & ~(1 << m_cs)));
            chk(cur_req, "model bus8", bus8, m_bw);
            chk(cur_req, "model cyc_rdy", cyc_rdy, m_rdy);
            chk(cur_req, "model bus_ack", bus_ack, m_ack);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int idx, input int data);
        cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Length counts negedges from the start edge to the negedge showing ready.
    task automatic do_cycle(input int addr, input int exp_cs, input int exp_w8,
                            input int exp_len, input int rel, input string req);
        int cnt;
        cyc_addr = 24'(addr); cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0; cnt = 1;
        chk(req, "cs_n in cycle", cs_n, exp_cs);
        chk(req, "bus8 in cycle", bus8, exp_w8);
        while (!cyc_rdy && cnt < 40) begin
            if (cnt == rel) wait_n = 1'b1;
            @(negedge clk);
            cnt++;
        end
        chk(req, "cycle length", cnt, exp_len);
        wait_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cur_req = "R1";
        chk("R1", "cs_n after reset", cs_n, 15);
        chk("R1", "bus8 after reset", bus8, 0);
        chk("R1", "cyc_rdy after reset", cyc_rdy, 0);
        chk("R1", "bus_ack after reset", bus_ack, 0);
        do_cycle(24'h123456, 11, 0, 4, 0, "R1");

        // R12 programming, R2 decode
        cur_req = "R12";
        wr(0, 8'h89); wr(34, 8'h10); wr(50, 8'hF0);
        wr(8, 8'hC3); wr(42, 8'h80); wr(58, 8'h80);
        wr(16, 8'h0D);
        cur_req = "R2";
        do_cycle(24'h150000, 14, 1, 3, 0, "R2");
        chk("R8", "bus8 idle after cycle", bus8, 0);

        // R11 scope set, R4 default area
        cur_req = "R4";
        do_cycle(24'h200000, 15, 1, 5, 0, "R4");
        cur_req = "R11";
        wait_n = 1'b0;
        do_cycle(24'h900000, 11, 0, 2, 0, "R6");

        // R2 full-width match on area 3 and waveform field
        cur_req = "R2";
        wr(12, 8'h8B); wr(44, 8'h5A); wr(60, 8'hFF); wr(46, 8'h30); wr(62, 8'hFF);
        do_cycle(24'h30005A, 7, 1, 2, 0, "R2");
        do_cycle(24'h30005B, 15, 1, 5, 0, "R2");
        wr(12, 8'h9B);
        do_cycle(24'h30005A, 15, 1, 5, 0, "R2");

        // R3 priority
        cur_req = "R3";
        wr(4, 8'h86); wr(38, 8'h10); wr(54, 8'hF0);
        do_cycle(24'h150000, 14, 1, 3, 0, "R3");
        wr(0, 8'h09);
        do_cycle(24'h150000, 13, 0, 6, 0, "R3");

        // R5 fixed codes, WAIT held low throughout
        cur_req = "R5";
        wr(4, 8'h80); wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 4, 0, "R5");
        wr(4, 8'h81); wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 3, 0, "R5");
        wr(4, 8'h85); wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 5, 0, "R5");
        wr(4, 8'h86); wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 6, 0, "R5");
        wr(4, 8'h8F); wait_n = 1'b0; do_cycle(24'h150000, 13, 1, 10, 0, "R5");

        // R7 stretch code
        cur_req = "R7";
        wr(4, 8'h82);
        do_cycle(24'h150000, 13, 0, 3, 0, "R7");
        wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 6, 5, "R7");
        wait_n = 1'b0; do_cycle(24'h150000, 13, 0, 10, 9, "R7");

        // R9 start during a running cycle
        cur_req = "R9";
        wr(4, 8'h86);
        begin
            int cnt;
            cyc_addr = 24'h150000; cyc_start = 1'b1;
            @(negedge clk); cyc_start = 1'b0; cnt = 1;
            @(negedge clk); cyc_start = 1'b1; cnt = 2;
            @(negedge clk); cyc_start = 1'b0; cnt = 3;
            while (!cyc_rdy && cnt < 40) begin @(negedge clk); cnt++; end
            chk("R9", "length with extra start", cnt, 6);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R9", "no cycle after ignored start", cs_n, 15);
            end
        end

        // R10 grant rules
        cur_req = "R10";
        wait_n = 1'b0; bus_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10", "no grant while WAIT low", bus_ack, 0);
        end
        wait_n = 1'b1;
        @(negedge clk);
        chk("R10", "grant after WAIT high", bus_ack, 1);
        cyc_addr = 24'h150000; cyc_start = 1'b1;
        @(negedge clk); cyc_start = 1'b0;
        chk("R9", "start ignored while granted", cs_n, 15);
        wait_n = 1'b0;
        @(negedge clk);
        chk("R10", "grant withdrawn on WAIT low", bus_ack, 0);
        wait_n = 1'b1;
        @(negedge clk);
        chk("R10", "grant restored", bus_ack, 1);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R10", "grant dropped with request", bus_ack, 0);

        // R10 start and request in the same clock
        cyc_addr = 24'h150000; cyc_start = 1'b1; bus_req = 1'b1;
        @(negedge clk); cyc_start = 1'b0;
        chk("R10", "cycle wins over request", cs_n, 13);
        chk("R10", "no grant during cycle", bus_ack, 0);
        begin
            int cnt;
            cnt = 1;
            while (!cyc_rdy && cnt < 40) begin @(negedge clk); cnt++; end
            chk("R10", "cycle length under request", cnt, 6);
            chk("R10", "no grant at ready", bus_ack, 0);
        end
        @(negedge clk);
        chk("R10", "grant one clock after ready", bus_ack, 1);
        bus_req = 1'b0;
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule